// File: doc/BRIEF.md
# Floating-Point Status and Exception Control Register

This block holds the floating-point status word of a processor core. The word carries a two-bit rounding-mode field, a denormal flush control bit, and three five-bit fields that share one bit order: the per-operation flags, the trap enables and the sticky cause bits. An FPU datapath outside the block reports each completed operation on a completion strobe. Alongside the strobe it gives five exception indications: invalid, divide-by-zero, overflow, underflow and inexact. A compare operation also reports whether its result was unordered.

On each operation the block replaces the flag field with the new indications. When any indication is present, it ORs them into the cause field. If the updated cause field shares a set bit with the enable field, the block raises a one-cycle exception request carrying the fixed code 0x120. Software can overwrite the word through a writable-bits mask. The rounding and flush controls are decoded continuously for the datapath.

Top module: `fpu_status_ctrl`

## Requirements
- R1: A completed operation replaces the flag field (bits 6:2) with the indications, in this order: inexact in bit 2, underflow in bit 3, overflow in bit 4, divide-by-zero in bit 5 and invalid in bit 6.
- R2: When at least one indication is present, the operation ORs the indications into the cause field (bits 16:12) in the same bit order. Cause bits that were already set stay set.
- R3: When an operation with at least one indication leaves the cause field (bits 16:12) and the enable field (bits 11:7) with a common set bit, exc_req is high for exactly the following cycle and exc_code reads 0x120. At all other times exc_code reads 0.
- R4: An operation with no indication leaves the cause field unchanged, clears the flag field and raises no exception request.
- R5: A software write stores wr_data AND 0x003FFFFF, so bits 31:22 read as 0. In the same cycle as an operation the software write takes priority, the operation is discarded and no exception request is raised.
- R6: round_to_zero is 1 exactly when bits 1:0 hold 2'b01. The three other encodings select round-to-nearest-even (round_to_zero is 0).
- R7: flush_to_zero follows bit 18 of the status word.
- R8: A compare that reports unordered updates the word as in R1 to R4. An ordered compare leaves the whole word unchanged and raises no request.
- R9: After reset the status word is 0 and exc_req is 0. With no operation and no write, the word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| op_done | input | 1 | FP operation completed this cycle |
| op_is_cmp | input | 1 | The completed operation is a compare |
| cmp_unord | input | 1 | The compare result is unordered |
| exc_ind | input | 5 | Indications {invalid, divzero, overflow, underflow, inexact} |
| status | output | 32 | Current status word |
| round_to_zero | output | 1 | Round-toward-zero selected |
| flush_to_zero | output | 1 | Denormal flush enabled |
| exc_req | output | 1 | Exception request pulse |
| exc_code | output | 12 | Exception code, 0x120 while exc_req is high, else 0 |

## Verification
A software write and an operation completion can fall in the same cycle. The bench provokes this by strobing wr_en together with op_done and a nonzero indication vector under enabled traps. It then judges that the status word equals the masked write value and that no exception request follows. The bench also sweeps all 32 indication patterns against several enable and prior-cause settings, and checks each against an arithmetic model.

// File: rtl/fpsr_pkg.sv
// Package: field positions and constants of the FP status word.
// Assumes a 32-bit word; all three five-bit fields share one bit order.
package fpsr_pkg;
    localparam int WORD_W   = 32;
    localparam int NIND     = 5;
    localparam int RM_LO    = 0;
    localparam int RM_W     = 2;
    localparam int FLAG_LO  = 2;
    localparam int EN_LO    = 7;
    localparam int CAUSE_LO = 12;
    localparam int DN_BIT   = 18;
    localparam int CODE_W   = 12;
    localparam logic [WORD_W-1:0] WR_MASK  = 32'h003F_FFFF;
    localparam logic [RM_W-1:0]   RM_RTZ   = 2'b01;
    localparam logic [CODE_W-1:0] EXC_CODE = 12'h120;
endpackage

// File: rtl/fpsr_field_place.sv
// Module: places an indication vector at a field position in a word.
// Assumes LO + NIND <= WORD_W. The result is combinational only.
module fpsr_field_place #(
    parameter int WORD_W = 32,
    parameter int NIND   = 5,
    parameter int LO     = 2
) (
    input  logic [NIND-1:0]   ind,
    output logic [WORD_W-1:0] placed
);
    // One bit per indication, all other bits zero
    for (genvar k = 0; k < WORD_W; k++) begin : g_bit
        if (k >= LO && k < LO + NIND) begin : g_in
            assign placed[k] = ind[k-LO];
        end else begin : g_out
            assign placed[k] = 1'b0;
        end
    end
endmodule

// File: rtl/fpsr_update.sv
// Module: computes the next status word and the trap decision.
// Assumes the software write already has priority outside this block.
module fpsr_update
    import fpsr_pkg::*;
(
    input  logic [WORD_W-1:0] cur,
    input  logic              op_done,
    input  logic              op_is_cmp,
    input  logic              cmp_unord,
    input  logic [NIND-1:0]   exc_ind,
    output logic [WORD_W-1:0] nxt,
    output logic              trap
);
    localparam logic [WORD_W-1:0] FLAG_FIELD = {{(WORD_W-NIND){1'b0}}, {NIND{1'b1}}} << FLAG_LO;

    logic [WORD_W-1:0] flag_bits;
    logic [WORD_W-1:0] cause_bits;
    logic              take;
    logic              any_ind;
    logic [NIND-1:0]   cause_new;
    logic [NIND-1:0]   enables;

    fpsr_field_place #(.WORD_W(WORD_W), .NIND(NIND), .LO(FLAG_LO))  u_flag  (.ind(exc_ind), .placed(flag_bits));
    fpsr_field_place #(.WORD_W(WORD_W), .NIND(NIND), .LO(CAUSE_LO)) u_cause (.ind(exc_ind), .placed(cause_bits));

    // Decide whether this completion touches the word at all
    always_comb begin
        take    = op_done && (!op_is_cmp || cmp_unord);
        any_ind = |exc_ind;
    end

    // Build the next word and the trap decision
    always_comb begin
        nxt = cur;
        if (take) begin
            nxt = (cur & ~FLAG_FIELD) | flag_bits;
            if (any_ind) begin
                nxt = nxt | cause_bits;
            end
        end
        cause_new = nxt[CAUSE_LO +: NIND];
        enables   = nxt[EN_LO +: NIND];
        trap      = take && any_ind && (|(cause_new & enables));
    end
endmodule

// File: rtl/fpsr_mode_decode.sv
// Module: decodes the rounding and flush controls from the status word.
// Assumes only one encoding of the mode field selects round-to-zero.
module fpsr_mode_decode
    import fpsr_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              rtz,
    output logic              ftz
);
    // Continuous decode of the mode controls
    always_comb begin
        rtz = (word[RM_LO +: RM_W] == RM_RTZ);
        ftz = word[DN_BIT];
    end
endmodule

// File: rtl/fpu_status_ctrl.sv
// Module: floating-point status register with trap request.
// Assumes at most one operation completion per cycle. A software write wins
// over an operation in the same cycle. The request is registered, one pulse.
module fpu_status_ctrl
    import fpsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              op_done,
    input  logic              op_is_cmp,
    input  logic              cmp_unord,
    input  logic [4:0]        exc_ind,
    output logic [31:0]       status,
    output logic              round_to_zero,
    output logic              flush_to_zero,
    output logic              exc_req,
    output logic [11:0]       exc_code
);
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_upd;
    logic              trap_upd;
    logic              req_q;

    fpsr_update u_upd (
        .cur(word_q), .op_done(op_done), .op_is_cmp(op_is_cmp),
        .cmp_unord(cmp_unord), .exc_ind(exc_ind), .nxt(word_upd), .trap(trap_upd)
    );

    fpsr_mode_decode u_dec (.word(word_q), .rtz(round_to_zero), .ftz(flush_to_zero));

    // Status word register: reset, then software write, then operation update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            req_q  <= 1'b0;
        end else if (wr_en) begin
            word_q <= wr_data & WR_MASK;
            req_q  <= 1'b0;
        end else begin
            word_q <= word_upd;
            req_q  <= trap_upd;
        end
    end

    // Drive outputs
    always_comb begin
        status   = word_q;
        exc_req  = req_q;
        exc_code = req_q ? EXC_CODE : '0;
    end
endmodule

// File: rtl/fpu_status_ctrl_chk.sv
// Module: assertion checker bound to fpu_status_ctrl.
module fpu_status_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        op_done,
    input logic        op_is_cmp,
    input logic        cmp_unord,
    input logic [4:0]  exc_ind,
    input logic [31:0] status,
    input logic        exc_req
);
    // R5
    sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (status == ($past(wr_data) & 32'h003F_FFFF)) && !exc_req);
    // R1
    flag_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !op_is_cmp && !wr_en) |=> status[6:2] == $past(exc_ind));
    // R4
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !wr_en && exc_ind == 5'd0) |=> $stable(status[16:12]) && !exc_req);
    // R3
    req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> $past(op_done) && !$past(wr_en) && ($past(exc_ind) != 5'd0));
    // R8
    ordered_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && op_is_cmp && !cmp_unord && !wr_en) |=> $stable(status) && !exc_req);
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_done && !wr_en) |=> $stable(status) && !exc_req);
endmodule

bind fpu_status_ctrl fpu_status_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .op_done(op_done), .op_is_cmp(op_is_cmp), .cmp_unord(cmp_unord),
    .exc_ind(exc_ind), .status(status), .exc_req(exc_req)
);

// File: tb/tb_fpu_status_ctrl.sv
module tb_fpu_status_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        op_done = 1'b0;
    logic        op_is_cmp = 1'b0;
    logic        cmp_unord = 1'b0;
    logic [4:0]  exc_ind = '0;
    logic [31:0] status;
    logic        round_to_zero, flush_to_zero, exc_req;
    logic [11:0] exc_code;

    int errors = 0;
    int checks = 0;
    logic [31:0] m_word = '0;
    logic        m_req = 1'b0;

    always #10 clk = ~clk;

    fpu_status_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .op_done(op_done), .op_is_cmp(op_is_cmp), .cmp_unord(cmp_unord),
        .exc_ind(exc_ind), .status(status), .round_to_zero(round_to_zero),
        .flush_to_zero(flush_to_zero), .exc_req(exc_req), .exc_code(exc_code)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare all outputs against the model
    task automatic check_all(input string req);
        check(req, status, m_word);
        check(req, {31'd0, exc_req}, {31'd0, m_req});
        check(req, {20'd0, exc_code}, m_req ? 32'h120 : 32'h0);
        check("R6", {31'd0, round_to_zero}, {31'd0, m_word[1:0] == 2'b01});
        check("R7", {31'd0, flush_to_zero}, {31'd0, m_word[18]});
    endtask

    // Apply one cycle of stimulus, update model, check after the edge
    task automatic cycle(input logic we, input logic [31:0] wd, input logic od,
                         input logic cmp, input logic un, input logic [4:0] ind,
                         input string req);
        @(negedge clk);
        wr_en = we; wr_data = wd; op_done = od; op_is_cmp = cmp; cmp_unord = un; exc_ind = ind;
        if (we) begin
            m_word = wd & 32'h003F_FFFF;
            m_req  = 1'b0;
        end else if (od && (!cmp || un)) begin
            m_word = (m_word & ~32'h7C) | ({27'd0, ind} << 2);
            if (ind != 0) m_word = m_word | ({27'd0, ind} << 12);
            m_req = (ind != 0) && ((((m_word >> 12) & (m_word >> 7)) & 32'h1F) != 0);
        end else begin
            m_req = 1'b0;
        end
        @(negedge clk);
        check_all(req);
        wr_en = 1'b0; op_done = 1'b0; op_is_cmp = 1'b0; cmp_unord = 1'b0; exc_ind = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_all("R9");
        rst_n = 1'b1;
        // R1 R2 R3 R4: sweep indications against enable and prior cause settings
        for (int en = 0; en < 4; en++) begin
            for (int pc = 0; pc < 3; pc++) begin
                for (int ind = 0; ind < 32; ind++) begin
                    logic [4:0] e5, c5;
                    e5 = (en == 0) ? 5'h00 : (en == 1) ? 5'h1F : (en == 2) ? 5'h01 : 5'h12;
                    c5 = (pc == 0) ? 5'h00 : (pc == 1) ? 5'h10 : 5'h05;
                    cycle(1'b1, {15'd0, c5, e5, 5'h0A, 2'b00}, 1'b0, 1'b0, 1'b0, 5'd0, "R5");
                    cycle(1'b0, 32'd0, 1'b1, 1'b0, 1'b0, ind[4:0], (ind == 0) ? "R4" : "R1_R2_R3");
                    cycle(1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 5'd0, "R9");
                end
            end
        end
        // R8: ordered compare leaves word, unordered compare updates it
        cycle(1'b1, 32'h0000_0F80, 1'b0, 1'b0, 1'b0, 5'd0, "R5");
        cycle(1'b0, 32'd0, 1'b1, 1'b1, 1'b0, 5'h10, "R8");
        cycle(1'b0, 32'd0, 1'b1, 1'b1, 1'b1, 5'h10, "R8");
        cycle(1'b0, 32'd0, 1'b1, 1'b1, 1'b0, 5'h00, "R8");
        // R5: write and operation in the same cycle, traps enabled
        cycle(1'b1, 32'h0000_0F80, 1'b0, 1'b0, 1'b0, 5'd0, "R5");
        cycle(1'b1, 32'hFFC0_0F81, 1'b1, 1'b0, 1'b0, 5'h1F, "R5");
        cycle(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 5'd0, "R5");
        // R6 R7: every rounding encoding, flush bit on and off
        for (int rm = 0; rm < 4; rm++) begin
            cycle(1'b1, {13'd0, rm[0], 16'd0, rm[1:0]}, 1'b0, 1'b0, 1'b0, 5'd0, "R6_R7");
        end
        // R3: back-to-back trapping operations keep pulsing, then drop
        cycle(1'b1, 32'h0000_0080, 1'b0, 1'b0, 1'b0, 5'd0, "R5");
        cycle(1'b0, 32'd0, 1'b1, 1'b0, 1'b0, 5'h01, "R3");
        cycle(1'b0, 32'd0, 1'b1, 1'b0, 1'b0, 5'h02, "R3");
        cycle(1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 5'h00, "R3");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule